// File: doc/BRIEF.md
# T1 Facility Data Link Tap

This block sits beside a T1 framer and handles the data-link bits that ride in the framing-bit position. On the transmit side it takes a frame-aligned bit stream from the framer, together with the frame number and bit position inside the frame. It then replaces the framing bits that belong to the data link with a bit from the currently selected link source. On the receive side it watches the aligned incoming stream and copies each data-link bit out to the selected sink.

Two framings are handled. In extended-superframe mode the link uses the framing bit of odd-numbered frames. In the SLC-96 style mode it uses the signalling framing bits, which are the framing bits of even-numbered frames. Either way the link runs at 4 kbit/s.

Three sources compete for the link, in a fixed priority:
- external serial pins, served by a per-bit strobe;
- a bit-oriented message generator;
- an internal HDLC controller.

When no source is enabled, the transmitter fills the link slots with ones. The interrupt line of the HDLC controller is passed on only while that controller owns the link.

Top module: `t1_fdl_tap`

## Requirements
- R1: With `mode`=0 (extended superframe), a link slot is bit position 0 of a frame whose number (1..24) is odd. In the cycle after a transmit slot, `tx_data_out` carries the bit of the selected source, as sampled in the slot cycle.
- R2: With `mode`=1 (SLC-96), a link slot is bit position 0 of an even-numbered frame, with the same one-cycle transmit behaviour as R1.
- R3: Every bit that is not a link slot is copied from `tx_data_in` to `tx_data_out` one cycle later. This covers framing bits of non-link frames and all payload bits.
- R4: The source is chosen by priority: `ext_en` first, then `bom_en`, then `hdlc_en`. A lower source has no effect on `tx_data_out` while a higher one is enabled.
- R5: When none of `ext_en`, `bom_en` or `hdlc_en` is set, every transmit link slot is sent as 1.
- R6: `tx_ext_clk` is high, combinationally, in exactly the transmit slot cycles. `tx_bom_req` and `tx_hdlc_req` are high in a slot cycle only when their source is the one selected.
- R7: One cycle after a receive slot, `rx_ext_clk` pulses for one cycle and `rx_dl_bit` holds the slot bit. `rx_dl_bit` keeps that value until the next slot. `rx_bom_valid` and `rx_hdlc_valid` pulse alongside `rx_ext_clk` only when their source is selected.
- R8: `hdlc_irq_out` equals `hdlc_irq_in` while the HDLC controller is the selected source, and is 0 otherwise.
- R9: After reset, `tx_data_out` is 1 and `rx_ext_clk`, `rx_dl_bit`, `rx_bom_valid` and `rx_hdlc_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = extended superframe, 1 = SLC-96 |
| ext_en | input | 1 | External pins own the link |
| bom_en | input | 1 | Bit-oriented message generator enabled |
| hdlc_en | input | 1 | HDLC controller enabled |
| tx_data_in | input | 1 | Framer transmit bit |
| tx_frame | input | 5 | Transmit frame number, 1..24 |
| tx_bit | input | 8 | Transmit bit position, 0..192, 0 = framing bit |
| tx_ext_bit | input | 1 | External link bit, sampled on tx_ext_clk |
| tx_bom_bit | input | 1 | Message generator link bit |
| tx_hdlc_bit | input | 1 | HDLC controller link bit |
| tx_data_out | output | 1 | Transmit stream with link inserted |
| tx_ext_clk | output | 1 | Transmit link strobe toward the external pins |
| tx_bom_req | output | 1 | Bit taken from the message generator |
| tx_hdlc_req | output | 1 | Bit taken from the HDLC controller |
| rx_data_in | input | 1 | Received aligned bit |
| rx_frame | input | 5 | Receive frame number, 1..24 |
| rx_bit | input | 8 | Receive bit position |
| rx_ext_clk | output | 1 | Receive link strobe, data valid with it |
| rx_dl_bit | output | 1 | Last received link bit |
| rx_bom_valid | output | 1 | Link bit for the message receiver |
| rx_hdlc_valid | output | 1 | Link bit for the HDLC receiver |
| hdlc_irq_in | input | 1 | Interrupt from the HDLC controller |
| hdlc_irq_out | output | 1 | Gated HDLC interrupt |

## Verification
The bench walks every frame number of a superframe in both framings. It checks that link bits land only on odd frames in one mode and only on even frames in the other. A design that swapped the parity, or let frame 24 wrap to odd, would overwrite the framer's own framing bits and corrupt alignment. It then sweeps all eight combinations of the enables with different data on each source. A priority error would send message or HDLC bits while the external pins were meant to own the link, and a wrong idle case would send zeros instead of ones. On the receive side the bench checks that `rx_dl_bit` holds between slots, and that the strobes and the HDLC interrupt appear only for the owning source. A leaky gate would show up as interrupts or strobes for a disconnected controller.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_EXT  = 2'd1,
      SRC_BOM  = 2'd2,
      SRC_HDLC = 2'd3
   } fdl_src_e;
endpackage

// File: rtl/fdl_slot_detect.sv
module fdl_slot_detect #(
   parameter int FRAME_BITS  = 193,
   parameter int SF_FRAMES   = 24,
   parameter bit SUPPORT_SLC = 1'b1,
   localparam int FW = $clog2(SF_FRAMES + 1),
   localparam int BW = $clog2(FRAME_BITS)
) (
   input  logic          mode,
   input  logic [FW-1:0] frame,
   input  logic [BW-1:0] bitpos,
   output logic          slot
);
   logic fbit;
   logic in_range;

   assign fbit     = (bitpos == '0);
   assign in_range = (frame != '0) && (int'(frame) <= SF_FRAMES);

   generate
      if (SUPPORT_SLC) begin : g_both
         // odd frames carry the link in ESF, even frames in SLC-96
         assign slot = fbit && in_range && (frame[0] ^ mode);
      end else begin : g_esf_only
         logic unused_mode;
         assign unused_mode = mode;
         assign slot = fbit && in_range && frame[0];
      end
   endgenerate
endmodule

// File: rtl/fdl_src_select.sv
module fdl_src_select
   import fdl_pkg::*;
(
   input  logic     ext_en,
   input  logic     bom_en,
   input  logic     hdlc_en,
   output fdl_src_e src
);
   always_comb begin
      if (ext_en)       src = SRC_EXT;
      else if (bom_en)  src = SRC_BOM;
      else if (hdlc_en) src = SRC_HDLC;
      else              src = SRC_NONE;
   end
endmodule

// File: rtl/fdl_tx_path.sv
module fdl_tx_path
   import fdl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     slot,
   input  fdl_src_e src,
   input  logic     data_in,
   input  logic     ext_bit,
   input  logic     bom_bit,
   input  logic     hdlc_bit,
   output logic     data_out,
   output logic     ext_clk,
   output logic     bom_req,
   output logic     hdlc_req
);
   logic link_bit;
   logic nxt;

   always_comb begin
      case (src)
         SRC_EXT:  link_bit = ext_bit;
         SRC_BOM:  link_bit = bom_bit;
         SRC_HDLC: link_bit = hdlc_bit;
         default:  link_bit = 1'b1;
      endcase
      nxt = slot ? link_bit : data_in;
   end

   assign ext_clk  = slot;
   assign bom_req  = slot && (src == SRC_BOM);
   assign hdlc_req = slot && (src == SRC_HDLC);

   always_ff @(posedge clk) begin
      if (!rst_n) data_out <= 1'b1;
      else        data_out <= nxt;
   end

   a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      !slot |=> data_out == $past(data_in));
   a_r5_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (slot && src == SRC_NONE) |=> data_out);
   a_r6_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bom_req, hdlc_req}) && ((bom_req || hdlc_req) -> ext_clk));
endmodule

// File: rtl/fdl_rx_path.sv
module fdl_rx_path
   import fdl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     slot,
   input  fdl_src_e src,
   input  logic     data_in,
   output logic     ext_clk,
   output logic     dl_bit,
   output logic     bom_valid,
   output logic     hdlc_valid
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_clk    <= 1'b0;
         dl_bit     <= 1'b0;
         bom_valid  <= 1'b0;
         hdlc_valid <= 1'b0;
      end else begin
         ext_clk    <= slot;
         bom_valid  <= slot && (src == SRC_BOM);
         hdlc_valid <= slot && (src == SRC_HDLC);
         if (slot) dl_bit <= data_in;
      end
   end

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !slot |=> $stable(dl_bit));
   a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
      ext_clk |-> !$past(ext_clk) || $past(slot));
endmodule

// File: rtl/t1_fdl_tap.sv
module t1_fdl_tap
   import fdl_pkg::*;
#(
   parameter int FRAME_BITS  = 193,
   parameter int SF_FRAMES   = 24,
   parameter bit SUPPORT_SLC = 1'b1,
   localparam int FW = $clog2(SF_FRAMES + 1),
   localparam int BW = $clog2(FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode,
   input  logic          ext_en,
   input  logic          bom_en,
   input  logic          hdlc_en,
   input  logic          tx_data_in,
   input  logic [FW-1:0] tx_frame,
   input  logic [BW-1:0] tx_bit,
   input  logic          tx_ext_bit,
   input  logic          tx_bom_bit,
   input  logic          tx_hdlc_bit,
   output logic          tx_data_out,
   output logic          tx_ext_clk,
   output logic          tx_bom_req,
   output logic          tx_hdlc_req,
   input  logic          rx_data_in,
   input  logic [FW-1:0] rx_frame,
   input  logic [BW-1:0] rx_bit,
   output logic          rx_ext_clk,
   output logic          rx_dl_bit,
   output logic          rx_bom_valid,
   output logic          rx_hdlc_valid,
   input  logic          hdlc_irq_in,
   output logic          hdlc_irq_out
);
   initial begin
      assert (FRAME_BITS > 1)
         else $error("FRAME_BITS must exceed 1");
      assert (SF_FRAMES >= 2 && SF_FRAMES % 2 == 0)
         else $error("SF_FRAMES must be even and at least 2");
   end

   fdl_src_e src;
   logic     tx_slot;
   logic     rx_slot;

   fdl_src_select u_sel (
      .ext_en  (ext_en),
      .bom_en  (bom_en),
      .hdlc_en (hdlc_en),
      .src     (src)
   );

   fdl_slot_detect #(.FRAME_BITS(FRAME_BITS), .SF_FRAMES(SF_FRAMES),
                     .SUPPORT_SLC(SUPPORT_SLC)) u_tx_slot (
      .mode   (mode),
      .frame  (tx_frame),
      .bitpos (tx_bit),
      .slot   (tx_slot)
   );

   fdl_slot_detect #(.FRAME_BITS(FRAME_BITS), .SF_FRAMES(SF_FRAMES),
                     .SUPPORT_SLC(SUPPORT_SLC)) u_rx_slot (
      .mode   (mode),
      .frame  (rx_frame),
      .bitpos (rx_bit),
      .slot   (rx_slot)
   );

   fdl_tx_path u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot     (tx_slot),
      .src      (src),
      .data_in  (tx_data_in),
      .ext_bit  (tx_ext_bit),
      .bom_bit  (tx_bom_bit),
      .hdlc_bit (tx_hdlc_bit),
      .data_out (tx_data_out),
      .ext_clk  (tx_ext_clk),
      .bom_req  (tx_bom_req),
      .hdlc_req (tx_hdlc_req)
   );

   fdl_rx_path u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot       (rx_slot),
      .src        (src),
      .data_in    (rx_data_in),
      .ext_clk    (rx_ext_clk),
      .dl_bit     (rx_dl_bit),
      .bom_valid  (rx_bom_valid),
      .hdlc_valid (rx_hdlc_valid)
   );

   assign hdlc_irq_out = hdlc_irq_in && (src == SRC_HDLC);

   a_r1_strobe_fbit: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ext_clk |-> (tx_bit == '0));
   a_r4_ext_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ext_clk && ext_en) |=> tx_data_out == $past(tx_ext_bit));
   a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_en || bom_en || !hdlc_en) |-> !hdlc_irq_out);
   a_r7_rx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ext_clk |-> $past(rx_bit) == '0);
endmodule

// File: tb/t1_fdl_tap_test.sv
module t1_fdl_tap_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode = 1'b0;
   logic       ext_en = 1'b0, bom_en = 1'b0, hdlc_en = 1'b0;
   logic       tx_data_in = 1'b0;
   logic [4:0] tx_frame = 5'd1;
   logic [7:0] tx_bit = 8'd5;
   logic       tx_ext_bit = 1'b0, tx_bom_bit = 1'b0, tx_hdlc_bit = 1'b0;
   logic       tx_data_out, tx_ext_clk, tx_bom_req, tx_hdlc_req;
   logic       rx_data_in = 1'b0;
   logic [4:0] rx_frame = 5'd1;
   logic [7:0] rx_bit = 8'd5;
   logic       rx_ext_clk, rx_dl_bit, rx_bom_valid, rx_hdlc_valid;
   logic       hdlc_irq_in = 1'b0;
   logic       hdlc_irq_out;

   int checks = 0;
   int errors = 0;
   logic held = 1'b0;

   always #5 clk = ~clk;

   t1_fdl_tap uut (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .ext_en(ext_en), .bom_en(bom_en), .hdlc_en(hdlc_en),
      .tx_data_in(tx_data_in), .tx_frame(tx_frame), .tx_bit(tx_bit),
      .tx_ext_bit(tx_ext_bit), .tx_bom_bit(tx_bom_bit), .tx_hdlc_bit(tx_hdlc_bit),
      .tx_data_out(tx_data_out), .tx_ext_clk(tx_ext_clk),
      .tx_bom_req(tx_bom_req), .tx_hdlc_req(tx_hdlc_req),
      .rx_data_in(rx_data_in), .rx_frame(rx_frame), .rx_bit(rx_bit),
      .rx_ext_clk(rx_ext_clk), .rx_dl_bit(rx_dl_bit),
      .rx_bom_valid(rx_bom_valid), .rx_hdlc_valid(rx_hdlc_valid),
      .hdlc_irq_in(hdlc_irq_in), .hdlc_irq_out(hdlc_irq_out)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b (mode=%0d frame=%0d bit=%0d en=%b%b%b)",
                  tag, act, exp, mode, tx_frame, tx_bit, ext_en, bom_en, hdlc_en);
      end
   endtask

   // One bit time: drive at negedge, check comb outputs, then registered ones.
   task automatic cyc(input logic [4:0] fr, input logic [7:0] bp,
                      input logic din, input logic eb, input logic bb,
                      input logic hb, input logic irq);
      logic slot, exp_tx, ext_sel, bom_sel, hdlc_sel;
      string ttag;
      @(negedge clk);
      tx_frame = fr; tx_bit = bp; rx_frame = fr; rx_bit = bp;
      tx_data_in = din; rx_data_in = din;
      tx_ext_bit = eb; tx_bom_bit = bb; tx_hdlc_bit = hb; hdlc_irq_in = irq;
      slot = (bp == 8'd0) && (fr >= 5'd1) && (fr <= 5'd24) && (fr[0] ^ mode);
      ext_sel = ext_en;
      bom_sel = !ext_en && bom_en;
      hdlc_sel = !ext_en && !bom_en && hdlc_en;
      exp_tx = !slot ? din : ext_sel ? eb : bom_sel ? bb : hdlc_sel ? hb : 1'b1;
      if (!slot) ttag = "R3";
      else if (!(ext_en || bom_en || hdlc_en)) ttag = "R5";
      else if (int'(ext_en) + int'(bom_en) + int'(hdlc_en) > 1) ttag = "R4";
      else ttag = mode ? "R2" : "R1";
      #1;
      chk("R6 tx_ext_clk", tx_ext_clk, slot);
      chk("R6 tx_bom_req", tx_bom_req, slot && bom_sel);
      chk("R6 tx_hdlc_req", tx_hdlc_req, slot && hdlc_sel);
      chk("R8 hdlc_irq_out", hdlc_irq_out, irq && hdlc_sel);
      @(posedge clk); #1;
      chk(ttag, tx_data_out, exp_tx);
      if (slot) held = din;
      chk("R7 rx_ext_clk", rx_ext_clk, slot);
      chk("R7 rx_dl_bit", rx_dl_bit, held);
      chk("R7 rx_bom_valid", rx_bom_valid, slot && bom_sel);
      chk("R7 rx_hdlc_valid", rx_hdlc_valid, slot && hdlc_sel);
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R9 tx_data_out", tx_data_out, 1'b1);
      chk("R9 rx_ext_clk", rx_ext_clk, 1'b0);
      chk("R9 rx_dl_bit", rx_dl_bit, 1'b0);
      chk("R9 rx_bom_valid", rx_bom_valid, 1'b0);
      chk("R9 rx_hdlc_valid", rx_hdlc_valid, 1'b0);
      held = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Walk a superframe visiting the framing bit and some payload bits.
   task automatic sweep_superframe();
      for (int f = 1; f <= 24; f++) begin
         cyc(5'(f), 8'd0, f[1], ~f[0], f[2], f[1] ^ f[0], 1'b1);
         cyc(5'(f), 8'd1, ~f[1], 1'b0, 1'b1, 1'b0, 1'b0);
         cyc(5'(f), 8'd192, f[2], 1'b1, 1'b0, 1'b1, 1'b1);
      end
   endtask

   task automatic test_esf();
      mode = 1'b0; ext_en = 1'b1; bom_en = 1'b0; hdlc_en = 1'b0;
      sweep_superframe();  // R1, R3
   endtask

   task automatic test_slc();
      mode = 1'b1; ext_en = 1'b0; bom_en = 1'b1; hdlc_en = 1'b0;
      sweep_superframe();  // R2, R3
   endtask

   task automatic test_priority();
      for (int m = 0; m < 2; m++) begin
         for (int e = 0; e < 8; e++) begin
            mode = m[0];
            {ext_en, bom_en, hdlc_en} = e[2:0];  // R4, R5, R8
            for (int p = 0; p < 8; p++) begin
               cyc(m[0] ? 5'd2 : 5'd3, 8'd0, 1'b0, p[0], p[1], p[2], 1'b1);
               cyc(m[0] ? 5'd24 : 5'd23, 8'd0, 1'b1, ~p[0], ~p[1], ~p[2], p[0]);
               cyc(5'd7, 8'd40, p[1], 1'b1, 1'b1, 1'b1, 1'b1);
            end
         end
      end
   endtask

   task automatic test_rx_hold();
      mode = 1'b0; ext_en = 1'b0; bom_en = 1'b0; hdlc_en = 1'b1;
      cyc(5'd5, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);   // R7 capture
      cyc(5'd5, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);   // R7 hold
      cyc(5'd6, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);   // R7 non-slot framing bit
      cyc(5'd7, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);   // R7 new bit
      cyc(5'd7, 8'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
   endtask

   initial begin
      fork
         begin
            test_reset();
            test_esf();
            test_slc();
            test_priority();
            test_rx_hold();
            test_reset();
         end
         begin
            repeat (100000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule